// File: doc/BRIEF.md
# Prepaid Call Meter

The block meters one prepaid telephone call at a time. While no call is in progress it mirrors the preset credit given on its input. When the exchange raises the call-active line, the block captures the call-type code. It then decides whether the credit covers the first minute at that type's tariff. If the credit is short, or the code is the reserved one, the call is refused and held refused until the exchange releases the line.

Once connected, the block counts seconds and minutes from a one-cycle second tick. It deducts the per-minute tariff at connect and again at every minute boundary. A warning is raised as soon as the remaining credit drops under a threshold. If the warning lasts a full minute of ticks, the call is dropped. Releasing the call-active line returns the block to its idle state with cleared counters. The call type, credit and duration are presented as plain binary values for a separate display driver.

Top module: `call_meter`

## Requirements
- R1: A synchronous active-high reset clears call_en, low_warn, blocked, disp_sec, disp_min and disp_bal to zero. In idle, disp_bal loads preset_bal on every clock edge.
- R2: Type codes 0 (local, tariff 3), 1 (long-distance, tariff 8) and 2 (international, tariff 15) are accepted when the credit is at least the tariff. In that case call_en rises two edges after call_req is first sampled high, and the tariff is deducted once at connect.
- R3: Type code 3, or a credit below the type's tariff, refuses the call. blocked rises, call_en stays low, the credit is unchanged and second ticks are ignored until call_req falls.
- R4: During a call each sec_tick advances disp_sec. On the tick taken at 59, disp_sec returns to 0 and disp_min advances.
- R5: disp_min saturates at 99.
- R6: Each minute boundary deducts the type's tariff from the credit again. The credit saturates at 0 instead of wrapping.
- R7: During a connected call, low_warn is high whenever the credit is below 20. call_en stays high while warning.
- R8: On the 60th sec_tick counted while low_warn is high, call_en and low_warn fall and blocked rises. This holds until call_req falls.
- R9: When call_req falls, the block returns to idle within one edge. Within two edges disp_sec, disp_min, low_warn and blocked are zero.
- R10: disp_type shows the call-type code captured when the call was requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Call active from the exchange |
| call_type | input | 2 | Requested call-type code |
| preset_bal | input | 16 | Preset credit loaded while idle |
| sec_tick | input | 1 | One-cycle pulse per second |
| call_en | output | 1 | Call connected |
| low_warn | output | 1 | Low-credit warning |
| blocked | output | 1 | Call refused or cut off |
| disp_type | output | 2 | Captured call type |
| disp_bal | output | 16 | Remaining credit |
| disp_sec | output | 6 | Seconds of the current minute |
| disp_min | output | 7 | Minutes elapsed |

## Verification
The cutoff on warning timeout and the minute-boundary deduction can fall on the same tick. When the credit is already below the threshold right after the connect charge, the warning starts before the first tick. Its 60th tick is then also the seconds wrap. The bench provokes this with international and local calls at small credit. It judges the result by the credit being reduced exactly once (saturating at zero for the international case), disp_min stepping to 1, disp_sec returning to 0, call_en falling and blocked rising.

// File: rtl/call_meter_pkg.sv
package call_meter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_TALK,
    ST_WARN,
    ST_CUTOFF
  } meter_state_t;

  typedef enum logic [1:0] {
    KIND_LOCAL = 2'd0,
    KIND_LONG  = 2'd1,
    KIND_INTL  = 2'd2,
    KIND_RSVD  = 2'd3
  } call_kind_t;

  // Tariff lookup per type code; reserved code yields zero.
  function automatic int unsigned pick_rate(input logic [1:0] kind,
                                            input int unsigned r_loc,
                                            input int unsigned r_long,
                                            input int unsigned r_intl);
    case (kind)
      KIND_LOCAL: return r_loc;
      KIND_LONG:  return r_long;
      KIND_INTL:  return r_intl;
      default:    return 0;
    endcase
  endfunction

  // Subtraction that stops at zero.
  function automatic logic [31:0] drain(input logic [31:0] bal,
                                        input logic [31:0] amt);
    return (bal > amt) ? (bal - amt) : 32'd0;
  endfunction

endpackage

// File: rtl/call_meter_fsm.sv
module call_meter_fsm
  import call_meter_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         call_req,
  input  logic         afford,
  input  logic         low,
  input  logic         warn_done,
  output meter_state_t state_q
);

  meter_state_t state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (call_req) state_d = ST_CHECK;
      ST_CHECK: begin
        if (!call_req)    state_d = ST_IDLE;
        else if (!afford) state_d = ST_CUTOFF;
        else              state_d = ST_TALK;
      end
      ST_TALK: begin
        if (!call_req) state_d = ST_IDLE;
        else if (low)  state_d = ST_WARN;
      end
      ST_WARN: begin
        if (!call_req)      state_d = ST_IDLE;
        else if (warn_done) state_d = ST_CUTOFF;
        else if (!low)      state_d = ST_TALK;
      end
      ST_CUTOFF: if (!call_req) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/call_meter_duration.sv
module call_meter_duration #(
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MIN_MAX     = 99,
  localparam int SEC_W = $clog2(SEC_PER_MIN),
  localparam int MIN_W = $clog2(MIN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  output logic [SEC_W-1:0] sec_q,
  output logic [MIN_W-1:0] min_q,
  output logic             wrap
);

  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] MIN_TOP  = MIN_W'(MIN_MAX);

  assign wrap = run && tick && (sec_q == SEC_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (wrap) begin
      sec_q <= '0;
      if (min_q != MIN_TOP) min_q <= min_q + 1'b1;
    end else if (run && tick) begin
      sec_q <= sec_q + 1'b1;
    end
  end

endmodule

// File: rtl/call_meter_purse.sv
module call_meter_purse
  import call_meter_pkg::*;
#(
  parameter int unsigned BAL_W       = 16,
  parameter int unsigned RATE_LOCAL  = 3,
  parameter int unsigned RATE_LONG   = 8,
  parameter int unsigned RATE_INTL   = 15,
  parameter int unsigned LOW_THRESH  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BAL_W-1:0] preset,
  input  logic [1:0]       kind,
  input  logic             charge,
  output logic [BAL_W-1:0] bal_q,
  output logic             afford,
  output logic             low
);

  logic [BAL_W-1:0] rate;

  assign rate   = BAL_W'(pick_rate(kind, RATE_LOCAL, RATE_LONG, RATE_INTL));
  assign afford = (kind != KIND_RSVD) && (bal_q >= rate);
  assign low    = bal_q < BAL_W'(LOW_THRESH);

  always_ff @(posedge clk) begin
    if (rst)         bal_q <= '0;
    else if (load)   bal_q <= preset;
    else if (charge) bal_q <= BAL_W'(drain(32'(bal_q), 32'(rate)));
  end

endmodule

// File: rtl/call_meter_warn_timer.sv
module call_meter_warn_timer #(
  parameter int unsigned WARN_SECS = 60,
  localparam int CW = $clog2(WARN_SECS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  output logic done
);

  logic [CW-1:0] cnt_q;

  assign done = active && tick && (cnt_q == CW'(WARN_SECS - 1));

  always_ff @(posedge clk) begin
    if (rst || !active)   cnt_q <= '0;
    else if (done)        cnt_q <= '0;
    else if (tick)        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/call_meter.sv
module call_meter
  import call_meter_pkg::*;
#(
  parameter int unsigned BAL_W       = 16,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MIN_MAX     = 99,
  parameter int unsigned RATE_LOCAL  = 3,
  parameter int unsigned RATE_LONG   = 8,
  parameter int unsigned RATE_INTL   = 15,
  parameter int unsigned LOW_THRESH  = 20,
  parameter int unsigned WARN_SECS   = 60,
  localparam int SEC_W = $clog2(SEC_PER_MIN),
  localparam int MIN_W = $clog2(MIN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_req,
  input  logic [1:0]       call_type,
  input  logic [BAL_W-1:0] preset_bal,
  input  logic             sec_tick,
  output logic             call_en,
  output logic             low_warn,
  output logic             blocked,
  output logic [1:0]       disp_type,
  output logic [BAL_W-1:0] disp_bal,
  output logic [SEC_W-1:0] disp_sec,
  output logic [MIN_W-1:0] disp_min
);

  meter_state_t state_q;
  logic [1:0]   kind_q;
  logic         afford, low, warn_done;
  logic         in_idle, in_call;
  logic         connect_evt, wrap_evt, charge_evt;

  assign in_idle     = (state_q == ST_IDLE);
  assign in_call     = (state_q == ST_TALK) || (state_q == ST_WARN);
  assign connect_evt = (state_q == ST_CHECK) && call_req && afford;
  assign charge_evt  = connect_evt || wrap_evt;

  always_ff @(posedge clk) begin
    if (rst)          kind_q <= '0;
    else if (in_idle) kind_q <= call_type;
  end

  call_meter_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .call_req  (call_req),
    .afford    (afford),
    .low       (low),
    .warn_done (warn_done),
    .state_q   (state_q)
  );

  call_meter_purse #(
    .BAL_W      (BAL_W),
    .RATE_LOCAL (RATE_LOCAL),
    .RATE_LONG  (RATE_LONG),
    .RATE_INTL  (RATE_INTL),
    .LOW_THRESH (LOW_THRESH)
  ) u_purse (
    .clk    (clk),
    .rst    (rst),
    .load   (in_idle),
    .preset (preset_bal),
    .kind   (kind_q),
    .charge (charge_evt),
    .bal_q  (disp_bal),
    .afford (afford),
    .low    (low)
  );

  call_meter_duration #(
    .SEC_PER_MIN (SEC_PER_MIN),
    .MIN_MAX     (MIN_MAX)
  ) u_dur (
    .clk   (clk),
    .rst   (rst),
    .clr   (in_idle),
    .run   (in_call),
    .tick  (sec_tick),
    .sec_q (disp_sec),
    .min_q (disp_min),
    .wrap  (wrap_evt)
  );

  call_meter_warn_timer #(
    .WARN_SECS (WARN_SECS)
  ) u_warn (
    .clk    (clk),
    .rst    (rst),
    .active (state_q == ST_WARN),
    .tick   (sec_tick),
    .done   (warn_done)
  );

  assign call_en   = in_call;
  assign low_warn  = (state_q == ST_WARN);
  assign blocked   = (state_q == ST_CUTOFF);
  assign disp_type = kind_q;

endmodule

// File: rtl/call_meter_chk.sv
module call_meter_chk #(
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MIN_MAX     = 99,
  parameter int unsigned LOW_THRESH  = 20,
  parameter int unsigned WARN_SECS   = 60
) (
  input logic        clk,
  input logic        rst,
  input logic        call_req,
  input logic        sec_tick,
  input logic        call_en,
  input logic        low_warn,
  input logic        blocked,
  input logic [15:0] disp_bal,
  input logic [5:0]  disp_sec,
  input logic [6:0]  disp_min,
  input logic        charge_evt,
  input logic        wrap_evt
);

  logic [7:0] wticks;

  always_ff @(posedge clk) begin
    if (rst || !low_warn) wticks <= '0;
    else if (sec_tick)    wticks <= wticks + 1'b1;
  end

  assert_en_blk_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(call_en && blocked));

  assert_sec_range_R4: assert property (@(posedge clk) disable iff (rst)
    disp_sec < 6'(SEC_PER_MIN));

  assert_wrap_step_R4: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (disp_sec == 6'd0) &&
      ((disp_min == $past(disp_min) + 7'd1) || ($past(disp_min) == 7'(MIN_MAX))));

  assert_min_sat_R5: assert property (@(posedge clk) disable iff (rst)
    disp_min <= 7'(MIN_MAX));

  assert_charge_drops_R6: assert property (@(posedge clk) disable iff (rst)
    charge_evt |=> (disp_bal < $past(disp_bal)) || ($past(disp_bal) == 16'd0));

  assert_bal_no_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (call_en && call_req) |=> (disp_bal <= $past(disp_bal)));

  assert_warn_low_R7: assert property (@(posedge clk) disable iff (rst)
    low_warn |-> (call_en && disp_bal < 16'(LOW_THRESH)));

  assert_cut_after_warn_R8: assert property (@(posedge clk) disable iff (rst)
    (wticks == 8'(WARN_SECS)) |-> (!call_en && blocked));

  assert_warn_window_R8: assert property (@(posedge clk) disable iff (rst)
    wticks <= 8'(WARN_SECS));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!call_req && $past(!call_req) && $past(!call_req, 2)) |->
      (disp_sec == 6'd0 && disp_min == 7'd0 && !low_warn && !blocked && !call_en));

endmodule

bind call_meter call_meter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .call_req   (call_req),
  .sec_tick   (sec_tick),
  .call_en    (call_en),
  .low_warn   (low_warn),
  .blocked    (blocked),
  .disp_bal   (disp_bal),
  .disp_sec   (disp_sec),
  .disp_min   (disp_min),
  .charge_evt (charge_evt),
  .wrap_evt   (wrap_evt)
);

// File: tb/call_meter_test.sv
`timescale 1ns/1ps
module call_meter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_req = 1'b0;
  logic [1:0]  call_type = 2'd0;
  logic [15:0] preset_bal = 16'd0;
  logic        sec_tick = 1'b0;
  logic        call_en, low_warn, blocked;
  logic [1:0]  disp_type;
  logic [15:0] disp_bal;
  logic [5:0]  disp_sec;
  logic [6:0]  disp_min;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  call_meter uut (
    .clk        (clk),
    .rst        (rst),
    .call_req   (call_req),
    .call_type  (call_type),
    .preset_bal (preset_bal),
    .sec_tick   (sec_tick),
    .call_en    (call_en),
    .low_warn   (low_warn),
    .blocked    (blocked),
    .disp_type  (disp_type),
    .disp_bal   (disp_bal),
    .disp_sec   (disp_sec),
    .disp_min   (disp_min)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] preset;
    logic [15:0] ticks;
    logic        en;
    logic        wrn;
    logic        blk;
    logic [15:0] bal;
    logic [5:0]  sec;
    logic [6:0]  min;
  } vec_t;

  // kind, preset, ticks -> call_en, low_warn, blocked, credit, sec, min
  localparam vec_t VECS [13] = '{
    '{2'd0, 16'd1000, 16'd0,   1'b1, 1'b0, 1'b0, 16'd997,  6'd0,  7'd0},
    '{2'd0, 16'd1000, 16'd59,  1'b1, 1'b0, 1'b0, 16'd997,  6'd59, 7'd0},
    '{2'd0, 16'd1000, 16'd60,  1'b1, 1'b0, 1'b0, 16'd994,  6'd0,  7'd1},
    '{2'd1, 16'd500,  16'd125, 1'b1, 1'b0, 1'b0, 16'd476,  6'd5,  7'd2},
    '{2'd2, 16'd100,  16'd30,  1'b1, 1'b0, 1'b0, 16'd85,   6'd30, 7'd0},
    '{2'd3, 16'd1000, 16'd5,   1'b0, 1'b0, 1'b1, 16'd1000, 6'd0,  7'd0},
    '{2'd1, 16'd7,    16'd0,   1'b0, 1'b0, 1'b1, 16'd7,    6'd0,  7'd0},
    '{2'd1, 16'd8,    16'd10,  1'b1, 1'b1, 1'b0, 16'd0,    6'd10, 7'd0},
    '{2'd2, 16'd25,   16'd60,  1'b0, 1'b0, 1'b1, 16'd0,    6'd0,  7'd1},
    '{2'd2, 16'd25,   16'd59,  1'b1, 1'b1, 1'b0, 16'd10,   6'd59, 7'd0},
    '{2'd0, 16'd21,   16'd60,  1'b0, 1'b0, 1'b1, 16'd15,   6'd0,  7'd1},
    '{2'd0, 16'd23,   16'd0,   1'b1, 1'b0, 1'b0, 16'd20,   6'd0,  7'd0},
    '{2'd0, 16'd23,   16'd61,  1'b1, 1'b1, 1'b0, 16'd17,   6'd1,  7'd1}
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic start_call(input logic [1:0] kind, input logic [15:0] preset);
    call_type  = kind;
    preset_bal = preset;
    call_req   = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_call(input logic [15:0] preset);
    call_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "cleared sec", 32'(disp_sec), 32'd0);
    check("R9", "cleared min", 32'(disp_min), 32'd0);
    check("R9", "cleared warn", 32'(low_warn), 32'd0);
    check("R9", "cleared blocked", 32'(blocked), 32'd0);
    check("R1", "idle credit follows preset", 32'(disp_bal), 32'(preset));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset call_en", 32'(call_en), 32'd0);
    check("R1", "reset warn", 32'(low_warn), 32'd0);
    check("R1", "reset blocked", 32'(blocked), 32'd0);
    check("R1", "reset sec", 32'(disp_sec), 32'd0);
    check("R1", "reset min", 32'(disp_min), 32'd0);
    check("R1", "reset credit", 32'(disp_bal), 32'd0);
    preset_bal = 16'd1234;
    rst = 1'b0;
    @(negedge clk);
    check("R1", "idle load", 32'(disp_bal), 32'd1234);

    for (int i = 0; i < 13; i++) begin
      start_call(VECS[i].kind, VECS[i].preset);
      ticks(int'(VECS[i].ticks));
      repeat (2) @(negedge clk);
      check("R2 R3 R8", $sformatf("v%0d call_en", i), 32'(call_en), 32'(VECS[i].en));
      check("R7", $sformatf("v%0d low_warn", i), 32'(low_warn), 32'(VECS[i].wrn));
      check("R3 R8", $sformatf("v%0d blocked", i), 32'(blocked), 32'(VECS[i].blk));
      check("R2 R6", $sformatf("v%0d credit", i), 32'(disp_bal), 32'(VECS[i].bal));
      check("R4", $sformatf("v%0d sec", i), 32'(disp_sec), 32'(VECS[i].sec));
      check("R4", $sformatf("v%0d min", i), 32'(disp_min), 32'(VECS[i].min));
      check("R10", $sformatf("v%0d type", i), 32'(disp_type), 32'(VECS[i].kind));
      end_call(VECS[i].preset);
    end

    // Connect timing: call_en after exactly two edges.
    call_type = 2'd1; preset_bal = 16'd300; call_req = 1'b1;
    @(negedge clk);
    check("R2", "call_en low after one edge", 32'(call_en), 32'd0);
    @(negedge clk);
    check("R2", "call_en high after two edges", 32'(call_en), 32'd1);
    check("R2", "connect charge", 32'(disp_bal), 32'd292);
    end_call(16'd300);

    // Minute saturation.
    start_call(2'd0, 16'd60000);
    ticks(5990);
    repeat (2) @(negedge clk);
    check("R5", "min at 99", 32'(disp_min), 32'd99);
    check("R4", "sec at 50", 32'(disp_sec), 32'd50);
    ticks(10);
    repeat (2) @(negedge clk);
    check("R5", "min held at 99", 32'(disp_min), 32'd99);
    check("R6", "credit after 100 boundaries", 32'(disp_bal), 32'd59697);
    end_call(16'd60000);

    // Reset in the middle of a call.
    start_call(2'd0, 16'd1000);
    ticks(5);
    rst = 1'b1; call_req = 1'b0;
    @(negedge clk);
    check("R1", "mid-call reset call_en", 32'(call_en), 32'd0);
    check("R1", "mid-call reset sec", 32'(disp_sec), 32'd0);
    check("R1", "mid-call reset credit", 32'(disp_bal), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "idle reload after reset", 32'(disp_bal), 32'd1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule